// File: doc/BRIEF.md
# Serial presence detect EEPROM

This block is a two-wire serial slave that holds the 256-byte description of a memory module. A host reads it over a clocked serial bus (SCL plus an open-drain SDA) to learn the module's geometry and timing. The lower 128 bytes are factory data. The host can read them but never change them. The upper 128 bytes are free for the host to write. A separate initialization port preloads or patches any byte at assembly time. A status bit reports whether byte 63 equals the modulo-256 sum of bytes 0 to 62.

Both bus lines pass through a two-flop synchroniser into the system clock domain. Start and stop conditions are recognised as SDA edges while SCL is high. The slave address is the fixed prefix `1010` followed by three strap inputs, so eight modules can share one bus. A byte pointer moves up by one after every byte read or written and wraps from 255 to 0. The pointer keeps its value across a repeated start and between transactions. This makes random reads (set pointer, repeated start, read) and current-address reads work.

The controller has nine states:
- IDLE: waits for a start.
- DEV: shifts in the address byte.
- ACKD: acknowledges the address.
- WORD: shifts in the pointer byte.
- ACKA: acknowledges the pointer byte.
- WDATA: shifts in a data byte.
- ACKW: acknowledges a data byte.
- RDATA: shifts out a byte.
- RACK: samples the host's acknowledge.

Transitions:
- A start in any state goes to DEV. A stop in any state goes to IDLE.
- At the end of DEV, a matching address goes to ACKD and any other address goes to IDLE.
- At the end of ACKD, a read goes to RDATA and a write goes to WORD.
- WORD goes to ACKA, then ACKA goes to WDATA.
- WDATA goes to ACKW, and ACKW returns to WDATA.
- RDATA goes to RACK. From RACK, an acknowledge goes back to RDATA and a not-acknowledge goes to IDLE.

Top module: `spd_eeprom`

## Requirements
- R1: After reset the array holds 0x80, 0x08, 0x07, 0x0D, 0x0A at bytes 0 to 4. Byte 63 holds 0xA6, their modulo-256 sum. Every other byte is 0x00.
- R2: A host data byte is stored at the pointer when the pointer lies in 0x80 to 0xFF and write-protect is low.
- R3: The slave answers only the address byte whose upper seven bits (MSB first) are `1010` followed by `strap_i[2:0]`; bit 0 is 1 for read, 0 for write. For any other address it never pulls SDA low until the next start.
- R4: Read data leaves MSB first, with one bit per SCL low phase. An acknowledge from the host continues with the next byte. A not-acknowledge ends the read and SDA is released.
- R5: The pointer increments after each byte read or written and wraps from 0xFF to 0x00. It keeps its value across a repeated start and a stop, so a read without a pointer byte continues where the last access ended.
- R6: A data byte aimed at 0x00 to 0x7F, or sent while write-protect is high, is acknowledged and leaves the array unchanged.
- R7: `csum_ok` is high exactly when byte 63 equals the modulo-256 sum of bytes 0 to 62. It changes only in the cycle after an initialization write.
- R8: The initialization port writes any byte whatever the lock and write-protect state. It takes priority over a host write in the same cycle.
- R9: A start while SCL is high (SDA falling) restarts address reception from any state, even mid-byte. A stop (SDA rising) returns the slave to IDLE with SDA released.
- R10: After each accepted address, pointer or data byte, the slave holds SDA low for the ninth SCL pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are oversampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | High pulls SDA low (open-drain drive) |
| strap_i | input | 3 | Board straps forming the low three address bits |
| wp_i | input | 1 | High blocks every host write |
| init_we | input | 1 | Initialization write strobe |
| init_addr | input | 8 | Initialization byte index |
| init_data | input | 8 | Initialization byte value |
| csum_ok | output | 1 | Byte 63 matches the sum of bytes 0 to 62 |

## Verification
A wrong pointer appears within one byte time as the wrong value on SDA. A full sequential read from 0 through the wrap, plus a current-address read, exposes a skip, a stall or a lost pointer. A lock fault stays hidden until the affected byte is read back, so a full readback follows the locked and write-protected write attempts. A stale running checksum shows on `csum_ok` one cycle after an initialization write. The bench checks this both as a mismatch and as a repaired match.

// File: rtl/spd_pkg.sv
package spd_pkg;

    // Index of the byte that carries the checksum of all bytes below it.
    localparam int unsigned CSUM_IDX = 63;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACKD,
        ST_WORD,
        ST_ACKA,
        ST_WDATA,
        ST_ACKW,
        ST_RDATA,
        ST_RACK
    } spd_state_e;

    // Factory configuration bytes before the checksum is added.
    function automatic logic [7:0] spd_base(input int unsigned idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h08;
            2:       return 8'h07;
            3:       return 8'h0D;
            4:       return 8'h0A;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] spd_sum(input int unsigned n);
        logic [7:0] acc;
        acc = '0;
        for (int unsigned i = 0; i < n; i++) begin
            acc = acc + spd_base(i);
        end
        return acc;
    endfunction

    function automatic logic [7:0] spd_image(input int unsigned idx);
        return (idx == CSUM_IDX) ? spd_sum(CSUM_IDX) : spd_base(idx);
    endfunction

endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Idle bus level is high on every line, so reset to ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [7:0]        init_data,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_data,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              csum_ok
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] CS_A = ADDR_W'(spd_pkg::CSUM_IDX);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] sum_q;
    logic       host_ok;

    // Upper half only, and never while write-protect is high.
    assign host_ok = host_we & host_addr[ADDR_W-1] & ~wp;

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= spd_pkg::spd_image(g);
            end else if (init_we && init_addr == ADDR_W'(g)) begin
                mem_q[g] <= init_data;
            end else if (host_ok && host_addr == ADDR_W'(g)) begin
                mem_q[g] <= host_data;
            end
        end
    end

    // Running sum of the checksummed region; only the init port reaches it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= spd_pkg::spd_sum(spd_pkg::CSUM_IDX);
        end else if (init_we && init_addr < CS_A) begin
            sum_q <= sum_q - mem_q[init_addr] + init_data;
        end
    end

    assign csum_ok = (sum_q == mem_q[CS_A]);
    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
    parameter int                   ADDR_W     = 8,
    parameter int                   STRAP_W    = 3,
    parameter logic [6-STRAP_W:0]   DEV_PREFIX = 4'b1010,
    parameter int                   SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic              wp_i,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [7:0]        init_data,
    output logic              csum_ok
);
    import spd_pkg::*;

    localparam logic [3:0] LAST_BIT = 4'd8;

    logic scl_s, sda_s, wp_s, scl_d, sda_d;
    logic scl_rise, scl_fall, start_det, stop_det, byte_end, addr_hit;

    spd_state_e        state_q, state_d;
    logic [3:0]        bitn_q;
    logic [7:0]        rx_q;
    logic [6:0]        tx_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              rw_q, nack_q;
    logic [7:0]        rd_data;
    logic              host_we;

    spd_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i, wp_i}),
        .q     ({scl_s, sda_s, wp_s})
    );

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    assign byte_end  = scl_fall & (bitn_q == LAST_BIT);
    assign addr_hit  = (rx_q[7:1] == {DEV_PREFIX, strap_i});
    assign host_we   = (state_q == ST_WDATA) & byte_end;

    spd_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .host_we   (host_we),
        .host_addr (ptr_q),
        .host_data (rx_q),
        .wp        (wp_s),
        .rd_addr   (ptr_q),
        .rd_data   (rd_data),
        .csum_ok   (csum_ok)
    );

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_DEV:   if (byte_end) state_d = addr_hit ? ST_ACKD : ST_IDLE;
                ST_ACKD:  if (scl_fall) state_d = rw_q ? ST_RDATA : ST_WORD;
                ST_WORD:  if (byte_end) state_d = ST_ACKA;
                ST_ACKA:  if (scl_fall) state_d = ST_WDATA;
                ST_WDATA: if (byte_end) state_d = ST_ACKW;
                ST_ACKW:  if (scl_fall) state_d = ST_WDATA;
                ST_RDATA: if (byte_end) state_d = ST_RACK;
                ST_RACK:  if (scl_fall) state_d = nack_q ? ST_IDLE : ST_RDATA;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
            bitn_q <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            ptr_q  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
            if (start_det || stop_det) begin
                bitn_q <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_DEV, ST_WORD, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_q   <= {rx_q[6:0], sda_s};
                            bitn_q <= bitn_q + 4'd1;
                        end
                        if (byte_end) begin
                            bitn_q <= '0;
                            sda_oe <= (state_q != ST_DEV) || addr_hit;
                            if (state_q == ST_DEV)   rw_q  <= rx_q[0];
                            if (state_q == ST_WORD)  ptr_q <= rx_q;
                            if (state_q == ST_WDATA) ptr_q <= ptr_q + 1'b1;
                        end
                    end
                    ST_ACKD, ST_ACKA, ST_ACKW: begin
                        if (scl_fall) begin
                            if (state_q == ST_ACKD && rw_q) begin
                                tx_q   <= rd_data[6:0];
                                sda_oe <= ~rd_data[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) bitn_q <= bitn_q + 4'd1;
                        if (scl_fall) begin
                            if (bitn_q == LAST_BIT) begin
                                sda_oe <= 1'b0;
                                bitn_q <= '0;
                                ptr_q  <= ptr_q + 1'b1;
                            end else begin
                                tx_q   <= {tx_q[5:0], 1'b0};
                                sda_oe <= ~tx_q[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (scl_fall && !nack_q) begin
                            tx_q   <= rd_data[6:0];
                            sda_oe <= ~rd_data[7];
                        end
                    end
                    ST_IDLE: begin
                        sda_oe <= 1'b0;
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk #(
    parameter int ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input spd_pkg::spd_state_e  state_q,
    input logic                 sda_oe,
    input logic                 stop_det,
    input logic                 init_we,
    input logic                 csum_ok,
    input logic [ADDR_W-1:0]    ptr_q
);
    import spd_pkg::*;

    // R9
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    // R10
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACKD || state_q == ST_ACKA || state_q == ST_ACKW) |-> sda_oe);

    // R4
    host_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RACK) |-> !sda_oe);

    // R7
    csum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(init_we) |-> $stable(csum_ok));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |->
            ((ptr_q == $past(ptr_q) + 1'b1) || ($past(state_q) == ST_WORD)));
endmodule

bind spd_eeprom spd_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .sda_oe   (sda_oe),
    .stop_det (stop_det),
    .init_we  (init_we),
    .csum_ok  (csum_ok),
    .ptr_q    (ptr_q)
);

// File: tb/sim_spd_eeprom.sv
module sim_spd_eeprom;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_bus;
    logic       sda_oe;
    logic [2:0] strap = 3'b101;
    logic       wp = 1'b0;
    logic       init_we = 1'b0;
    logic [7:0] init_addr = '0;
    logic [7:0] init_data = '0;
    logic       csum_ok;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_mem [256];

    always #4 clk = ~clk;

    assign sda_bus = ~(m_low | sda_oe);

    spd_eeprom u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .strap_i   (strap),
        .wp_i      (wp),
        .init_we   (init_we),
        .init_addr (init_addr),
        .init_data (init_data),
        .csum_ok   (csum_ok)
    );

    task automatic check_eq(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; tick(5);
        scl = 1'b1;   tick(10);
        m_low = 1'b1; tick(10);
        scl = 1'b0;   tick(5);
    endtask

    task automatic bus_stop;
        m_low = 1'b1; tick(5);
        scl = 1'b1;   tick(10);
        m_low = 1'b0; tick(10);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; tick(5);
        scl = 1'b1; tick(10);
        scl = 1'b0; tick(5);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; tick(5);
        scl = 1'b1;   tick(5);
        b = sda_bus;  tick(5);
        scl = 1'b0;   tick(5);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~more);
    endtask

    function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic read_seq(input int first, input int n, input string tag);
        logic a;
        logic [7:0] v;
        bus_start;
        send_byte(dev_byte(strap, 1'b0), a); check_eq("R10", a, 1);
        send_byte(first[7:0], a);            check_eq("R10", a, 1);
        bus_start;
        send_byte(dev_byte(strap, 1'b1), a); check_eq("R10", a, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            check_eq((i >= 256) ? "R5 wrap" : tag, v, exp_mem[(first + i) % 256]);
        end
        tick(3);
        check_eq("R4 release after nack", sda_oe, 0);
        bus_stop;
    endtask

    task automatic init_write(input logic [7:0] a, input logic [7:0] d);
        init_addr = a; init_data = d; init_we = 1'b1;
        tick(1);
        init_we = 1'b0;
        exp_mem[a] = d;
        tick(1);
    endtask

    function automatic logic exp_csum();
        logic [7:0] s;
        s = '0;
        for (int i = 0; i < 63; i++) s = s + exp_mem[i];
        return s == exp_mem[63];
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a;
        logic [7:0] v;

        // Reset image model: R1
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        exp_mem[0] = 8'h80; exp_mem[1] = 8'h08; exp_mem[2] = 8'h07;
        exp_mem[3] = 8'h0D; exp_mem[4] = 8'h0A;
        exp_mem[63] = exp_mem[0] + exp_mem[1] + exp_mem[2] + exp_mem[3] + exp_mem[4];

        tick(4);
        rst_n = 1'b1;
        tick(4);
        check_eq("R3 reset sda idle", sda_oe, 0);
        check_eq("R7 reset checksum", csum_ok, 1);

        // R3: sweep every strap value in the address byte.
        for (int s = 0; s < 8; s++) begin
            bus_start;
            send_byte(dev_byte(3'(s), 1'b0), a);
            check_eq("R3 address match", a, (s == 5) ? 1 : 0);
            bus_stop;
        end
        bus_start;
        send_byte(8'hA0 ^ 8'h40 | {4'b0, strap, 1'b0}, a);
        check_eq("R3 wrong prefix", a, 0);
        bus_stop;

        // R1, R4, R5: full read from 0 plus one byte past the wrap.
        read_seq(0, 257, "R1");

        // R5: current-address read continues at 1.
        bus_start;
        send_byte(dev_byte(strap, 1'b1), a); check_eq("R10", a, 1);
        recv_byte(v, 1'b0);
        check_eq("R5 current address", v, exp_mem[1]);
        bus_stop;

        // R2: sequential write of the whole upper half.
        bus_start;
        send_byte(dev_byte(strap, 1'b0), a); check_eq("R10", a, 1);
        send_byte(8'h80, a);                 check_eq("R10", a, 1);
        for (int i = 0; i < 128; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + 11) & 255);
            send_byte(d, a);
            check_eq("R10 data ack", a, 1);
            exp_mem[128 + i] = d;
        end
        bus_stop;

        // R6: writes into the locked half, including the checksum byte.
        bus_start;
        send_byte(dev_byte(strap, 1'b0), a); check_eq("R10", a, 1);
        send_byte(8'h3E, a);                 check_eq("R10", a, 1);
        send_byte(8'h55, a);                 check_eq("R6 locked ack", a, 1);
        send_byte(8'h66, a);                 check_eq("R6 locked ack", a, 1);
        bus_stop;
        check_eq("R7 host cannot touch checksum", csum_ok, 1);

        // R6: write-protect blocks an upper-half write.
        wp = 1'b1;
        tick(4);
        bus_start;
        send_byte(dev_byte(strap, 1'b0), a); check_eq("R10", a, 1);
        send_byte(8'hC0, a);                 check_eq("R10", a, 1);
        send_byte(8'h99, a);                 check_eq("R6 protected ack", a, 1);
        bus_stop;
        wp = 1'b0;
        tick(4);

        read_seq(0, 128, "R6");
        read_seq(128, 128, "R2");

        // R7, R8: initialization port.
        init_write(8'h05, 8'h11);
        check_eq("R7 checksum broken", csum_ok, exp_csum());
        init_write(8'h3F, exp_mem[63] + 8'h11);
        check_eq("R7 checksum repaired", csum_ok, exp_csum());
        wp = 1'b1;
        init_write(8'h90, 8'h42);
        init_write(8'h02, 8'h3C);
        check_eq("R7 checksum after low patch", csum_ok, exp_csum());
        tick(4);
        wp = 1'b0;
        tick(4);
        read_seq(2, 4, "R8");
        read_seq(8'h90, 1, "R8");

        // R9: start in the middle of a byte; pointer stays at 0x91.
        bus_start;
        send_byte(dev_byte(strap, 1'b0), a); check_eq("R10", a, 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start;
        send_byte(dev_byte(strap, 1'b1), a); check_eq("R9 restart ack", a, 1);
        recv_byte(v, 1'b0);
        check_eq("R9 resync read", v, exp_mem[8'h91]);
        bus_stop;
        tick(3);
        check_eq("R9 stop idle", sda_oe, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule